// File: doc/BRIEF.md
# Translation Buffer Register Port

This block is the software-facing register port of a translation buffer. A processor reaches the buffer's entry storage through a small set of special registers: a low entry word, a high entry word, an entry index, a search register, a process-ID register and a zone-protection register. The two entry words are not stored here. Each access to them goes to the entry picked by the index register. The block drives the write port of the entry storage and takes the combinational read data back from it.

Writing the search register sends a read-type lookup request to the translation logic. The request carries the page-number bits of the written value and the current privilege mode. While the lookup runs, the bus is stalled. When the result arrives, the block either loads the matching entry number into the index register or raises the index register's miss flag. The process-ID and zone registers are also driven out to the lookup logic. A strap input sets how much access software is granted.

Top module: `tlb_sreg_if`

## Requirements
- R1: After reset the index, process-ID and zone registers read as zero, `ready` is high and `srchReq` is low.
- R2: A write to the low (register 0) or high (register 1) entry word pulses `entWrLo` or `entWrHi` in the acceptance cycle, with `entIdx` equal to bits [7:0] of the index register and `entWrData` equal to the written value. A read of either word returns the storage word at that entry.
- R3: A write to the high entry word presents bits [7:0] of the process-ID register on `entWrTid`, so that this value is stored as the entry's TID.
- R4: A read of the high entry word replaces the process-ID register with the selected entry's TID, zero-extended.
- R5: A write to the search register (register 3) requests a lookup of the written value with bits below `PAGE_LSB` cleared, tagged with the `userMode` value sampled at the write. On a hit, the whole index register takes the returned entry number and the miss flag is cleared. On a miss, only bit 31 of the index register is set.
- R6: A write to the index register (register 2) updates bits [30:0] only. Bit 31 keeps its value.
- R7: `accessLvl` 0 rejects every access, and any read returns zero. `accessLvl` 1 allows all reads and allows writes to the entry words and the index register, but writes to process-ID (register 4), zone (register 5) and search have no effect. `accessLvl` 2 or 3 allows everything.
- R8: A read of the search register, or any access to register number 6 or 7, returns zero, changes no state and raises `accErr` for exactly the cycle after acceptance.
- R9: After an accepted search write, `ready` is low and `srchReq` is high from the next cycle until the cycle after `srchDone`. After that, `ready` is high again.
- R10: An access is accepted on a rising edge where `ready` and `rdEn` or `wrEn` are high; write takes priority. Read data appears on `rdData` in the cycle after acceptance and holds until the next accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| accessLvl | input | 2 | Software access grant strap |
| userMode | input | 1 | Current privilege mode, 1 = user |
| regSel | input | 3 | Register number |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| wrData | input | 32 | Write value |
| rdData | output | 32 | Registered read value |
| ready | output | 1 | Bus can accept an access |
| accErr | output | 1 | One-cycle illegal-access flag |
| entIdx | output | 8 | Selected entry number |
| entWrLo | output | 1 | Low entry word write strobe |
| entWrHi | output | 1 | High entry word and TID write strobe |
| entWrData | output | 32 | Entry write value |
| entWrTid | output | 8 | TID stored with a high-word write |
| entRdLo | input | 32 | Low word of selected entry |
| entRdHi | input | 32 | High word of selected entry |
| entRdTid | input | 8 | TID of selected entry |
| srchReq | output | 1 | Lookup request, held until done |
| srchPage | output | 32 | Page bits to look up |
| srchUser | output | 1 | Privilege mode of the lookup |
| srchDone | input | 1 | Lookup result valid |
| srchHit | input | 1 | Lookup found an entry |
| srchIdx | input | 8 | Matching entry number |
| curPid | output | 8 | Process ID toward lookup logic |
| zoneBits | output | 32 | Zone protection toward lookup logic |

## Verification
Entry writes are combinational strobes in the acceptance cycle, so the bench checks its storage model at the falling edge after that edge. Read data, `accErr`, and updates to the index and process-ID registers appear one cycle after acceptance, and the bench samples them at the next falling edge. The bench's lookup responder raises `srchDone` on the fourth cycle of a request. A search must therefore show `ready` low at exactly four falling edges, and the index result must be readable right after `ready` returns.

// File: rtl/tlb_sreg_pkg.sv
package tlb_sreg_pkg;

  typedef enum logic [2:0] {
    SEL_LO   = 3'd0,
    SEL_HI   = 3'd1,
    SEL_IDX  = 3'd2,
    SEL_SRCH = 3'd3,
    SEL_PID  = 3'd4,
    SEL_ZONE = 3'd5
  } regSel_e;

  typedef struct packed {
    logic wrLo;
    logic wrHi;
    logic wrIdx;
    logic wrPid;
    logic wrZone;
    logic srchStart;
    logic srchCapture;
    logic rdLo;
    logic rdHi;
    logic rdIdx;
    logic rdPid;
    logic rdZone;
    logic rdZero;
  } regStrobes_t;

  localparam logic [1:0] LVL_NONE = 2'd0;
  localparam logic [1:0] LVL_FULL = 2'd2;

endpackage

// File: rtl/tlb_sreg_ctrl.sv
module tlb_sreg_ctrl
  import tlb_sreg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  accessLvl,
  input  logic [2:0]  regSel,
  input  logic        rdEn,
  input  logic        wrEn,
  input  logic        srchDone,
  output regStrobes_t st,
  output logic        ready,
  output logic        srchBusy,
  output logic        accErr
);

  typedef enum logic {ST_IDLE, ST_SRCH} state_e;
  state_e state;

  logic accepted, isWr, isRd, lvlRd, lvlFull, badAcc;

  assign ready    = (state == ST_IDLE);
  assign srchBusy = (state == ST_SRCH);
  assign accepted = ready && (rdEn || wrEn);
  assign isWr     = accepted && wrEn;
  assign isRd     = accepted && !wrEn;
  assign lvlRd    = (accessLvl != LVL_NONE);
  assign lvlFull  = (accessLvl >= LVL_FULL);

  always_comb begin
    st = '0;
    badAcc = 1'b0;
    st.srchCapture = srchBusy && srchDone;
    if (isWr) begin
      case (regSel)
        SEL_LO:   st.wrLo      = lvlRd;
        SEL_HI:   st.wrHi      = lvlRd;
        SEL_IDX:  st.wrIdx     = lvlRd;
        SEL_SRCH: st.srchStart = lvlFull;
        SEL_PID:  st.wrPid     = lvlFull;
        SEL_ZONE: st.wrZone    = lvlFull;
        default:  badAcc       = 1'b1;
      endcase
    end else if (isRd) begin
      case (regSel)
        SEL_LO:   begin st.rdLo   = lvlRd; st.rdZero = !lvlRd; end
        SEL_HI:   begin st.rdHi   = lvlRd; st.rdZero = !lvlRd; end
        SEL_IDX:  begin st.rdIdx  = lvlRd; st.rdZero = !lvlRd; end
        SEL_PID:  begin st.rdPid  = lvlRd; st.rdZero = !lvlRd; end
        SEL_ZONE: begin st.rdZone = lvlRd; st.rdZero = !lvlRd; end
        default:  begin st.rdZero = 1'b1;  badAcc    = 1'b1;   end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      accErr <= 1'b0;
    end else begin
      accErr <= badAcc;
      case (state)
        ST_IDLE: if (st.srchStart) state <= ST_SRCH;
        ST_SRCH: if (srchDone)     state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9: accepted search write stalls the bus and raises the request
  a_r9_stall_on_search: assert property (@(posedge clk) disable iff (!rstN)
    st.srchStart |=> (!ready && srchBusy));

  // R9: bus is released after the result is captured
  a_r9_release_after_done: assert property (@(posedge clk) disable iff (!rstN)
    st.srchCapture |=> ready);

  // R8: an illegal access flags an error on the next cycle
  a_r8_error_flag: assert property (@(posedge clk) disable iff (!rstN)
    (isRd && regSel == SEL_SRCH) |=> accErr);

endmodule

// File: rtl/tlb_sreg_dp.sv
module tlb_sreg_dp
  import tlb_sreg_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ESEL_W   = 8,
  parameter int TID_W    = 8,
  parameter int PAGE_LSB = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobes_t       st,
  input  logic              userMode,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] entRdLo,
  input  logic [DATA_W-1:0] entRdHi,
  input  logic [TID_W-1:0]  entRdTid,
  input  logic              srchHit,
  input  logic [ESEL_W-1:0] srchIdx,
  output logic [DATA_W-1:0] rdData,
  output logic [ESEL_W-1:0] entIdx,
  output logic              entWrLo,
  output logic              entWrHi,
  output logic [DATA_W-1:0] entWrData,
  output logic [TID_W-1:0]  entWrTid,
  output logic [DATA_W-1:0] srchPage,
  output logic              srchUser,
  output logic [TID_W-1:0]  curPid,
  output logic [DATA_W-1:0] zoneBits
);

  localparam int MSB = DATA_W - 1;
  localparam logic [DATA_W-1:0] PAGE_MASK = ~((DATA_W'(1) << PAGE_LSB) - DATA_W'(1));

  logic [DATA_W-1:0] idxReg, pidReg, zoneReg, rdReg, pageReg;
  logic              userReg;

  assign entIdx    = idxReg[ESEL_W-1:0];
  assign entWrLo   = st.wrLo;
  assign entWrHi   = st.wrHi;
  assign entWrData = wrData;
  assign entWrTid  = pidReg[TID_W-1:0];
  assign srchPage  = pageReg;
  assign srchUser  = userReg;
  assign curPid    = pidReg[TID_W-1:0];
  assign zoneBits  = zoneReg;
  assign rdData    = rdReg;

  // index register: software write, search result
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxReg <= '0;
    end else if (st.srchCapture) begin
      if (srchHit) idxReg <= DATA_W'(srchIdx);
      else         idxReg[MSB] <= 1'b1;
    end else if (st.wrIdx) begin
      idxReg[MSB-1:0] <= wrData[MSB-1:0];
    end
  end

  // process ID and zone
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pidReg  <= '0;
      zoneReg <= '0;
    end else begin
      if (st.wrPid)       pidReg  <= wrData;
      else if (st.rdHi)   pidReg  <= DATA_W'(entRdTid);
      if (st.wrZone)      zoneReg <= wrData;
    end
  end

  // search request capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageReg <= '0;
      userReg <= 1'b0;
    end else if (st.srchStart) begin
      pageReg <= wrData & PAGE_MASK;
      userReg <= userMode;
    end
  end

  // read data
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdReg <= '0;
    end else if (st.rdZero) begin
      rdReg <= '0;
    end else if (st.rdLo) begin
      rdReg <= entRdLo;
    end else if (st.rdHi) begin
      rdReg <= entRdHi;
    end else if (st.rdIdx) begin
      rdReg <= idxReg;
    end else if (st.rdPid) begin
      rdReg <= pidReg;
    end else if (st.rdZone) begin
      rdReg <= zoneReg;
    end
  end

  // R5: hit loads the entry number and clears the flag
  a_r5_hit_loads_index: assert property (@(posedge clk) disable iff (!rstN)
    (st.srchCapture && srchHit) |=> (idxReg == DATA_W'($past(srchIdx))));

  // R5: miss sets only the flag
  a_r5_miss_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    (st.srchCapture && !srchHit) |=>
      (idxReg[MSB] && idxReg[MSB-1:0] == $past(idxReg[MSB-1:0])));

  // R6: software index write keeps the flag bit
  a_r6_flag_kept: assert property (@(posedge clk) disable iff (!rstN)
    (st.wrIdx && !st.srchCapture) |=> (idxReg[MSB] == $past(idxReg[MSB])));

  // R4: high-word read moves TID into process ID
  a_r4_tid_to_pid: assert property (@(posedge clk) disable iff (!rstN)
    (st.rdHi && !st.wrPid) |=> (pidReg == DATA_W'($past(entRdTid))));

  // R7: rejected reads return zero
  a_r7_reject_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    st.rdZero |=> (rdReg == '0));

endmodule

// File: rtl/tlb_sreg_if.sv
module tlb_sreg_if
  import tlb_sreg_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ESEL_W   = 8,
  parameter int TID_W    = 8,
  parameter int PAGE_LSB = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        accessLvl,
  input  logic              userMode,
  input  logic [2:0]        regSel,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              ready,
  output logic              accErr,
  output logic [ESEL_W-1:0] entIdx,
  output logic              entWrLo,
  output logic              entWrHi,
  output logic [DATA_W-1:0] entWrData,
  output logic [TID_W-1:0]  entWrTid,
  input  logic [DATA_W-1:0] entRdLo,
  input  logic [DATA_W-1:0] entRdHi,
  input  logic [TID_W-1:0]  entRdTid,
  output logic              srchReq,
  output logic [DATA_W-1:0] srchPage,
  output logic              srchUser,
  input  logic              srchDone,
  input  logic              srchHit,
  input  logic [ESEL_W-1:0] srchIdx,
  output logic [TID_W-1:0]  curPid,
  output logic [DATA_W-1:0] zoneBits
);

  regStrobes_t strobes;

  tlb_sreg_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .accessLvl(accessLvl),
    .regSel   (regSel),
    .rdEn     (rdEn),
    .wrEn     (wrEn),
    .srchDone (srchDone),
    .st       (strobes),
    .ready    (ready),
    .srchBusy (srchReq),
    .accErr   (accErr)
  );

  tlb_sreg_dp #(
    .DATA_W  (DATA_W),
    .ESEL_W  (ESEL_W),
    .TID_W   (TID_W),
    .PAGE_LSB(PAGE_LSB)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .st       (strobes),
    .userMode (userMode),
    .wrData   (wrData),
    .entRdLo  (entRdLo),
    .entRdHi  (entRdHi),
    .entRdTid (entRdTid),
    .srchHit  (srchHit),
    .srchIdx  (srchIdx),
    .rdData   (rdData),
    .entIdx   (entIdx),
    .entWrLo  (entWrLo),
    .entWrHi  (entWrHi),
    .entWrData(entWrData),
    .entWrTid (entWrTid),
    .srchPage (srchPage),
    .srchUser (srchUser),
    .curPid   (curPid),
    .zoneBits (zoneBits)
  );

endmodule

// File: tb/tlb_sreg_if_tb_top.sv
module tlb_sreg_if_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  accessLvl = 2'd3;
  logic        userMode = 1'b0;
  logic [2:0]  regSel = '0;
  logic        rdEn = 1'b0, wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        ready, accErr;
  logic [7:0]  entIdx;
  logic        entWrLo, entWrHi;
  logic [31:0] entWrData;
  logic [7:0]  entWrTid;
  logic        srchReq, srchUser;
  logic [31:0] srchPage;
  logic        srchDone;
  logic        respHit = 1'b0;
  logic [7:0]  respIdx = '0;
  logic [7:0]  curPid;
  logic [31:0] zoneBits;

  int checks = 0, fails = 0, cycles = 0;

  logic [31:0] memLo [256];
  logic [31:0] memHi [256];
  logic [7:0]  memTid [256];
  logic [3:0]  waitCnt;

  always #10 clk = ~clk;

  tlb_sreg_if dut_i (
    .clk(clk), .rstN(rstN), .accessLvl(accessLvl), .userMode(userMode),
    .regSel(regSel), .rdEn(rdEn), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .ready(ready), .accErr(accErr),
    .entIdx(entIdx), .entWrLo(entWrLo), .entWrHi(entWrHi),
    .entWrData(entWrData), .entWrTid(entWrTid),
    .entRdLo(memLo[entIdx]), .entRdHi(memHi[entIdx]), .entRdTid(memTid[entIdx]),
    .srchReq(srchReq), .srchPage(srchPage), .srchUser(srchUser),
    .srchDone(srchDone), .srchHit(respHit), .srchIdx(respIdx),
    .curPid(curPid), .zoneBits(zoneBits)
  );

  // entry storage model
  initial begin
    for (int i = 0; i < 256; i++) begin
      memLo[i] = '0; memHi[i] = '0; memTid[i] = '0;
    end
  end

  always @(posedge clk) begin
    if (entWrLo) memLo[entIdx] <= entWrData;
    if (entWrHi) begin
      memHi[entIdx]  <= entWrData;
      memTid[entIdx] <= entWrTid;
    end
  end

  // lookup responder: done on the fourth request cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt  <= '0;
      srchDone <= 1'b0;
    end else if (srchReq && !srchDone) begin
      waitCnt <= waitCnt + 4'd1;
      if (waitCnt == 4'd2) srchDone <= 1'b1;
    end else begin
      srchDone <= 1'b0;
      if (!srchReq) waitCnt <= '0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] sel, input logic [31:0] v);
    @(negedge clk);
    regSel = sel; wrData = v; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] sel, output logic [31:0] v);
    @(negedge clk);
    regSel = sel; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    v = rdData;
  endtask

  task automatic waitReady(output int lowCycles);
    lowCycles = 0;
    while (!ready && lowCycles < 50) begin
      lowCycles++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1 ready", {31'b0, ready}, 32'd1);
    check("R1 srchReq", {31'b0, srchReq}, 32'd0);
    busRead(3'd2, v); check("R1 index", v, 32'h0);
    busRead(3'd4, v); check("R1 pid", v, 32'h0);
    busRead(3'd5, v); check("R1 zone", v, 32'h0);
  endtask

  task automatic t_entry;
    logic [31:0] v;
    busWrite(3'd2, 32'h0000_0105);      // entry 5 via low 8 bits
    busWrite(3'd0, 32'hDEAD_BEEF);
    check("R2 low write", memLo[5], 32'hDEAD_BEEF);
    busWrite(3'd4, 32'h0000_01A3);
    busWrite(3'd1, 32'hCAFE_0040);
    check("R2 high write", memHi[5], 32'hCAFE_0040);
    check("R3 tid stored", {24'b0, memTid[5]}, 32'h0000_00A3);
    busRead(3'd0, v); check("R2 low read", v, 32'hDEAD_BEEF);
    busWrite(3'd4, 32'h0000_0007);
    busRead(3'd1, v); check("R4 high read", v, 32'hCAFE_0040);
    busRead(3'd4, v); check("R4 pid from tid", v, 32'h0000_00A3);
  endtask

  task automatic t_index;
    logic [31:0] v;
    busWrite(3'd2, 32'hFFFF_FFFF);
    busRead(3'd2, v); check("R6 msb protected", v, 32'h7FFF_FFFF);
    busWrite(3'd2, 32'h0000_0009);
    busRead(3'd2, v); check("R6 low bits", v, 32'h0000_0009);
  endtask

  task automatic t_search;
    logic [31:0] v;
    int low;
    respHit = 1'b0;
    userMode = 1'b1;
    busWrite(3'd3, 32'h1234_5ABC);
    userMode = 1'b0;
    check("R9 stall", {31'b0, ready}, 32'd0);
    check("R9 request", {31'b0, srchReq}, 32'd1);
    check("R5 page bits", srchPage, 32'h1234_5800);
    check("R5 mode", {31'b0, srchUser}, 32'd1);
    waitReady(low);
    check("R9 stall length", low, 32'd4);
    check("R9 request dropped", {31'b0, srchReq}, 32'd0);
    busRead(3'd2, v); check("R5 miss flag", v, 32'h8000_0009);
    respHit = 1'b1; respIdx = 8'h21;
    busWrite(3'd3, 32'h0000_0400);
    check("R5 user mode clear", {31'b0, srchUser}, 32'd0);
    waitReady(low);
    busRead(3'd2, v); check("R5 hit index", v, 32'h0000_0021);
  endtask

  task automatic t_illegal;
    logic [31:0] v;
    busRead(3'd3, v);
    check("R8 search read zero", v, 32'h0);
    check("R8 error flag", {31'b0, accErr}, 32'd1);
    @(negedge clk);
    check("R8 error one cycle", {31'b0, accErr}, 32'd0);
    busWrite(3'd7, 32'h0000_0055);
    check("R8 unknown write flag", {31'b0, accErr}, 32'd1);
    busRead(3'd2, v); check("R8 no state change", v, 32'h0000_0021);
    check("R8 no entry write", memLo[8'h55], 32'h0);
  endtask

  task automatic t_levels;
    logic [31:0] v;
    busWrite(3'd5, 32'h5555_AAAA);
    accessLvl = 2'd1;
    busWrite(3'd4, 32'h0000_0033);
    busRead(3'd4, v); check("R7 pid write rejected", v, 32'h0000_00A3);
    busWrite(3'd5, 32'h0);
    busRead(3'd5, v); check("R7 zone write rejected", v, 32'h5555_AAAA);
    busWrite(3'd3, 32'h0000_0000);
    check("R7 search rejected", {31'b0, ready, srchReq}, 32'd2);
    busWrite(3'd0, 32'h0000_1111);
    check("R7 level1 entry write", memLo[8'h21], 32'h0000_1111);
    accessLvl = 2'd0;
    busRead(3'd2, v); check("R7 level0 read zero", v, 32'h0);
    busWrite(3'd0, 32'h0000_2222);
    check("R7 level0 write rejected", memLo[8'h21], 32'h0000_1111);
    accessLvl = 2'd3;
  endtask

  task automatic t_hold;
    logic [31:0] v;
    busRead(3'd5, v);
    busWrite(3'd2, 32'h0000_0003);
    repeat (3) @(negedge clk);
    check("R10 read data held", rdData, 32'h5555_AAAA);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_entry();
    t_index();
    t_search();
    t_illegal();
    t_levels();
    t_hold();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule